// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a register-mapped interval timer for a low-power subsystem. A 32-bit up-counter advances on ticks taken from one of four clock-enable inputs. Each selected tick either counts directly or first passes through a power-of-two prescaler. When the count reaches the programmed compare value, a sticky compare flag sets. An interrupt line follows that flag when interrupts are enabled.

Software configures the timer while it is stopped, then sets the run bit. In the default mode the counter returns to zero on each match, so the interval is the compare value plus one ticks. Software can also select a free-running mode, in which the counter runs past the compare value and wraps at 2^32. The live count is never read directly. Any write to the counter location first copies the count into a snapshot register, and every read of that location returns the snapshot.

Top module: `lp_interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: While run (control bit 0) is set, each tick raises the count by one. A write to offset 0xC copies the live count into the snapshot.
- R3: With free-run (control bit 1) clear, the tick that finds the count equal to the compare value (offset 0x8) sets the flag (control bit 7) and returns the count to zero. The interval is therefore compare+1 ticks.
- R4: Writing 1 to control bit 7 clears the flag. Writing 0 there leaves the flag unchanged.
- R5: `irq` is high exactly while the flag and interrupt-enable (control bit 2) are both set.
- R6: While run is clear, the counter and the prescaler are held at zero, the flag is held cleared, and ticks have no effect.
- R7: Select field bits [1:0] at offset 0x4 choose which bit of `tickEn` counts. The other inputs are ignored.
- R8: With bypass (offset 0x4 bit 2) set, every selected tick counts. With bypass clear, prescale field N (offset 0x4 bits [6:3]) lets one tick in 2^(N+1) through.
- R9: With free-run set, a match sets the flag, the count keeps incrementing and wraps at 2^32.
- R10: A match in the same cycle as a write-one clear leaves the flag set. A match while the flag is already set keeps it set.
- R11: Reads of offset 0xC return the snapshot, which changes only on a write to that offset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and timer clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 4 | Byte offset: 0x0 control, 0x4 clock setup, 0x8 compare, 0xC snapshot |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data of the addressed register (combinational) |
| tickEn | input | 4 | Four clock-enable count sources |
| irq | output | 1 | Compare interrupt |

## Verification
The assertions assume that each bus access lasts a single cycle, with busSel low between accesses, and that the count sources change only between clock edges. The stimulus follows both assumptions. It drives bus and tick inputs one time unit after a rising edge and holds each access for one cycle. It also keeps tick inputs low during configuration writes and captures, so that snapshots are deterministic. The one exception is a deliberate collision between a match and a flag clear.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CLK  = 4'h4;
  localparam logic [3:0] OFS_CMP  = 4'h8;
  localparam logic [3:0] OFS_SNAP = 4'hC;

  localparam int BIT_RUN   = 0;
  localparam int BIT_FREE  = 1;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_FLAG  = 7;

  typedef struct packed {
    logic tick;
    logic hold;
    logic capture;
    logic freeRun;
  } lptStrobes_t;
endpackage

// File: rtl/lpt_ticker.sv
module lpt_ticker #(
  parameter int SRC_N = 4,
  parameter int PS_W  = 4,
  localparam int SEL_W = $clog2(SRC_N),
  localparam int PC_W  = 1 << PS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SRC_N-1:0] srcEn,
  input  logic [SEL_W-1:0] srcSel,
  input  logic             bypass,
  input  logic [PS_W-1:0]  prescale,
  input  logic             run,
  output logic             tick
);
  logic [SRC_N-1:0] selHot;
  logic             srcTick;
  logic [PC_W-1:0]  prescCnt;
  logic [PC_W:0]    limitWide;
  logic [PC_W-1:0]  limit;
  logic             prescHit;

  for (genvar gi = 0; gi < SRC_N; gi++) begin : gSel
    assign selHot[gi] = srcEn[gi] && (srcSel == SEL_W'(gi));
  end

  assign srcTick   = |selHot;
  assign limitWide = ((PC_W+1)'(1) << (32'(prescale) + 32'd1)) - (PC_W+1)'(1);
  assign limit     = limitWide[PC_W-1:0];
  assign prescHit  = (prescCnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN || !run || bypass) prescCnt <= '0;
    else if (srcTick) prescCnt <= prescHit ? '0 : prescCnt + PC_W'(1);
  end

  assign tick = run && srcTick && (bypass || prescHit);
endmodule

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
  import lpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SRC_N = 4,
  parameter int PS_W  = 4,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [3:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic             tick,
  input  logic             matchEv,
  input  logic [CNT_W-1:0] snapshot,
  output lptStrobes_t      strobes,
  output logic             run,
  output logic             freeRun,
  output logic             flag,
  output logic [SEL_W-1:0] srcSel,
  output logic             bypass,
  output logic [PS_W-1:0]  prescale,
  output logic [CNT_W-1:0] compare,
  output logic             irq
);
  logic irqEn;
  logic wrCtrl, wrClk, wrCmp, wrSnap;

  assign wrCtrl = busSel && busWrite && (busAddr == OFS_CTRL);
  assign wrClk  = busSel && busWrite && (busAddr == OFS_CLK);
  assign wrCmp  = busSel && busWrite && (busAddr == OFS_CMP);
  assign wrSnap = busSel && busWrite && (busAddr == OFS_SNAP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run     <= 1'b0;
      freeRun <= 1'b0;
      irqEn   <= 1'b0;
    end else if (wrCtrl) begin
      run     <= busWdata[BIT_RUN];
      freeRun <= busWdata[BIT_FREE];
      irqEn   <= busWdata[BIT_IRQEN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel   <= '0;
      bypass   <= 1'b0;
      prescale <= '0;
    end else if (wrClk) begin
      srcSel   <= busWdata[SEL_W-1:0];
      bypass   <= busWdata[2];
      prescale <= busWdata[3 +: PS_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) compare <= '0;
    else if (wrCmp) compare <= busWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !run) flag <= 1'b0;
    else if (matchEv) flag <= 1'b1;
    else if (wrCtrl && busWdata[BIT_FLAG]) flag <= 1'b0;
  end

  assign irq = flag && irqEn;

  always_comb begin
    strobes.tick    = tick;
    strobes.hold    = !run;
    strobes.capture = wrSnap;
    strobes.freeRun = freeRun;
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      OFS_CTRL: begin
        busRdata[BIT_RUN]   = run;
        busRdata[BIT_FREE]  = freeRun;
        busRdata[BIT_IRQEN] = irqEn;
        busRdata[BIT_FLAG]  = flag;
      end
      OFS_CLK: begin
        busRdata[SEL_W-1:0]  = srcSel;
        busRdata[2]          = bypass;
        busRdata[3 +: PS_W]  = prescale;
      end
      OFS_CMP:  busRdata = compare;
      OFS_SNAP: busRdata = snapshot;
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  lptStrobes_t      strobes,
  input  logic [CNT_W-1:0] compare,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] snapshot,
  output logic             matchEv
);
  logic atCompare;

  assign atCompare = (count == compare);
  assign matchEv   = strobes.tick && !strobes.hold && atCompare;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.hold) count <= '0;
    else if (strobes.tick) begin
      if (atCompare && !strobes.freeRun) count <= '0;
      else count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) snapshot <= '0;
    else if (strobes.capture) snapshot <= count;
  end
endmodule

// File: rtl/lp_interval_timer.sv
module lp_interval_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int SRC_N = 4,
  parameter int PS_W  = 4,
  localparam int SEL_W = $clog2(SRC_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [3:0]       busAddr,
  input  logic [CNT_W-1:0] busWdata,
  output logic [CNT_W-1:0] busRdata,
  input  logic [SRC_N-1:0] tickEn,
  output logic             irq
);
  lptStrobes_t      strobes;
  logic             run, freeRun, flag, bypass, tick, matchEv;
  logic [SEL_W-1:0] srcSel;
  logic [PS_W-1:0]  prescale;
  logic [CNT_W-1:0] compare, count, snapshot;

  lpt_ctrl #(.CNT_W(CNT_W), .SRC_N(SRC_N), .PS_W(PS_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tick(tick), .matchEv(matchEv), .snapshot(snapshot), .strobes(strobes),
    .run(run), .freeRun(freeRun), .flag(flag), .srcSel(srcSel),
    .bypass(bypass), .prescale(prescale), .compare(compare), .irq(irq)
  );

  lpt_ticker #(.SRC_N(SRC_N), .PS_W(PS_W)) u_ticker (
    .clk(clk), .rstN(rstN), .srcEn(tickEn), .srcSel(srcSel),
    .bypass(bypass), .prescale(prescale), .run(run), .tick(tick)
  );

  lpt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .compare(compare),
    .count(count), .snapshot(snapshot), .matchEv(matchEv)
  );
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busSel,
  input logic             busWrite,
  input logic [3:0]       busAddr,
  input logic [CNT_W-1:0] busWdata,
  input logic             run,
  input logic             freeRun,
  input logic             flag,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] snapshot,
  input logic             irq
);
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (count == '0) && !flag); // R6

  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !irq); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    flag && run && !(busSel && busWrite && busAddr == 4'h0 && busWdata[7]) |=> flag); // R4

  AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    run && !freeRun && !flag ##1 flag |-> count == '0); // R3

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    run ##1 run |-> (count == $past(count)) || (count == $past(count) + CNT_W'(1)) || (count == '0)); // R2

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !(busSel && busWrite && busAddr == 4'hC) |=> $stable(snapshot)); // R11
endmodule

bind lp_interval_timer lpt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .run(run), .freeRun(freeRun),
  .flag(flag), .count(count), .snapshot(snapshot), .irq(irq)
);

// File: tb/test_lp_interval_timer.sv
module test_lp_interval_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [3:0]  tickEn = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_interval_timer i_lp_interval_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickEn(tickEn), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard items as read data appears
  always @(negedge clk) begin
    if (busSel && !busWrite && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, busRdata, e);
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string tag);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic readCount(logic [31:0] exp, string tag);
    wr(4'hC, 32'h0);
    rd(4'hC, exp, tag);
  endtask

  task automatic ticks(logic [3:0] mask, int n);
    @(posedge clk); #1;
    tickEn = mask;
    repeat (n) @(posedge clk);
    #1 tickEn = '0;
  endtask

  task automatic irqCheck(logic exp, string tag);
    @(negedge clk);
    check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h4, 32'h0, "R1 clk");
    rd(4'h8, 32'h0, "R1 cmp");
    rd(4'hC, 32'h0, "R1 snap");
    irqCheck(1'b0, "R1 irq");

    // R2 counting, bypass, source 0, compare 5
    wr(4'h4, 32'h4);
    wr(4'h8, 32'd5);
    wr(4'h0, 32'h5);
    ticks(4'b0001, 3);
    readCount(32'd3, "R2 count after 3 ticks");
    rd(4'h0, 32'h05, "R2 flag still clear");

    // R3 match after compare+1 ticks
    ticks(4'b0001, 2);
    rd(4'h0, 32'h05, "R3 no flag before match");
    ticks(4'b0001, 1);
    readCount(32'd0, "R3 count returns to zero");
    rd(4'h0, 32'h85, "R3 flag set");
    irqCheck(1'b1, "R5 irq with flag and enable");

    // R11 snapshot holds until next capture
    ticks(4'b0001, 2);
    rd(4'hC, 32'd0, "R11 snapshot not live");
    readCount(32'd2, "R11 new capture");

    // R4 write-one-to-clear
    wr(4'h0, 32'h05);
    rd(4'h0, 32'h85, "R4 write zero keeps flag");
    wr(4'h0, 32'h85);
    rd(4'h0, 32'h05, "R4 write one clears flag");
    irqCheck(1'b0, "R5 irq low after clear");
    readCount(32'd2, "R4 ctrl write while running keeps count");

    // R5 interrupt masked
    wr(4'h0, 32'h01);
    ticks(4'b0001, 4);
    rd(4'h0, 32'h81, "R5 flag set with irq off");
    irqCheck(1'b0, "R5 irq masked");

    // R10 match colliding with clear
    ticks(4'b0001, 5);
    @(posedge clk); #1;
    tickEn = 4'b0001;
    busSel = 1'b1; busWrite = 1'b1; busAddr = 4'h0; busWdata = 32'h81;
    @(posedge clk); #1;
    tickEn = '0; busSel = 1'b0; busWrite = 1'b0;
    rd(4'h0, 32'h81, "R10 match wins over clear");
    wr(4'h0, 32'h81);
    rd(4'h0, 32'h01, "R10 later clear works");

    // R6 disable clears counter and flag, ticks ignored
    ticks(4'b0001, 6);
    ticks(4'b0001, 2);
    rd(4'h0, 32'h81, "R6 flag set before stop");
    wr(4'h0, 32'h00);
    readCount(32'd0, "R6 count zero when stopped");
    rd(4'h0, 32'h00, "R6 flag cleared when stopped");
    ticks(4'b0001, 3);
    readCount(32'd0, "R6 ticks ignored when stopped");

    // R7 source select
    wr(4'h4, 32'h6);
    wr(4'h0, 32'h01);
    ticks(4'b1011, 5);
    readCount(32'd0, "R7 other sources ignored");
    ticks(4'b0100, 3);
    readCount(32'd3, "R7 selected source counts");

    // R8 prescaler
    wr(4'h0, 32'h00);
    wr(4'h4, 32'h08);
    wr(4'h0, 32'h01);
    ticks(4'b0001, 9);
    readCount(32'd2, "R8 N=1 divides by 4");
    wr(4'h0, 32'h00);
    wr(4'h4, 32'h00);
    wr(4'h0, 32'h01);
    ticks(4'b0001, 7);
    readCount(32'd3, "R8 N=0 divides by 2, prescaler cleared");

    // R9 free-running
    wr(4'h0, 32'h00);
    wr(4'h4, 32'h4);
    wr(4'h8, 32'd2);
    wr(4'h0, 32'h03);
    ticks(4'b0001, 5);
    readCount(32'd5, "R9 count continues past compare");
    rd(4'h0, 32'h83, "R9 flag set in free-run");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL scoreboard: actual=%0d expected=0 pending", expQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule